// File: doc/BRIEF.md
# Hardware Real-Time Task Scheduler

This block picks which of a small set of periodic tasks should run. Each task is described once through a write port: an ID, a period, a relative deadline and the time of its first release. The task waits in a sleep queue until the time counter reaches its release time. It then moves to a ready queue, which is kept ordered by priority. The head of the ready queue is the task that should run. When that task is not the one held in the current-task register, the register takes the new ID and an interrupt is raised. The interrupt stays up until software acknowledges it.

Both queues are linear rows of cells. Each cell either holds its entry or loads one of three values: the entry of the cell on its left, the entry of the cell on its right, or an incoming entry. On an insert, each cell compares the incoming entry with its own, and the entries behind the insertion point move one place right. Removing the head moves every entry one place left. The ready-queue priority key is chosen by a mode input that may change at any time. In deadline mode the key is the absolute deadline of the release. In rate mode the key is the period. When the mode changes, the ready queue sorts itself again by swapping neighbouring cells on cycles that have no queue operation.

When the running task reports completion, it leaves the ready queue. It re-enters the sleep queue with its next release time, which is its previous release time plus its period. `cfg_we` and `done` must not be asserted in the same cycle; if they are, the write wins and `done` is ignored. A task ID is written at most once between resets.

Top module: `rt_task_sched`

## Requirements
- R1: After reset `irq` is 0, `cur_valid` is 0 and `now` is 0.
- R2: With `mode_rm`=0 the ready task with the smallest absolute deadline (release time plus relative deadline) becomes the current task. On equal keys the lower task ID wins.
- R3: With `mode_rm`=1 the ready task with the smallest period becomes the current task. On equal periods the lower task ID wins.
- R4: `mode_rm` may change while tasks are queued, with no reset. After NTASK+2 cycles without queue operations, the current task follows the new mode's order.
- R5: A sleeping task enters the ready queue once its release time is at or before `now`, and not earlier.
- R6: A `done` pulse removes the head of the ready queue. That task's next release time is its previous release time plus its period, and it waits in the sleep queue until then.
- R7: When the ready-queue head differs from the current task, or there is no current task, `cur_id` takes the head's ID, `cur_valid` goes to 1 and `irq` is set. If the head does not change, `irq` is not raised again.
- R8: An `ack` pulse clears `irq` when no new task switch occurs in the same cycle.
- R9: Each cycle with `tick`=1 increments `now` by one.
- R10: With the ready queue empty, `cur_valid` is 0.
- R11: Neither queue is inserted into while its last cell is occupied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_rm | input | 1 | Priority key: 0 = absolute deadline, 1 = period |
| tick | input | 1 | Advances the time counter by one |
| cfg_we | input | 1 | Writes a task and places it in the sleep queue |
| cfg_id | input | IDW | Task ID for the write |
| cfg_period | input | TW | Task period |
| cfg_rdl | input | TW | Relative deadline |
| cfg_rel | input | TW | First release time |
| done | input | 1 | Running task finished its current release |
| ack | input | 1 | Clears the interrupt |
| irq | output | 1 | A task switch is pending |
| cur_valid | output | 1 | A current task exists |
| cur_id | output | IDW | ID of the task that should run |
| now | output | TW | Time counter |

## Verification
A wrong internal state shows up at the ports either as the wrong current task or as a missing or extra interrupt. A mis-sorted or mis-shifted ready queue appears in `cur_id` one cycle after the head changes. A queue that loses or duplicates an entry appears later, when a chain of `done` pulses empties the queue in the wrong order or leaves `cur_valid` set. A wrong next-release computation stays hidden until the time counter passes the release time, so the bench advances time one tick at a time around each release.

// File: rtl/rt_task_sched.sv
module rt_task_sched #(
  parameter int NTASK = 4,
  parameter int TW    = 16,
  parameter int IDW   = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_rm,
  input  logic           tick,
  input  logic           cfg_we,
  input  logic [IDW-1:0] cfg_id,
  input  logic [TW-1:0]  cfg_period,
  input  logic [TW-1:0]  cfg_rdl,
  input  logic [TW-1:0]  cfg_rel,
  input  logic           done,
  input  logic           ack,
  output logic           irq,
  output logic           cur_valid,
  output logic [IDW-1:0] cur_id,
  output logic [TW-1:0]  now
);
  localparam logic [1:0] K_DL = 2'd0, K_PER = 2'd1, K_REL = 2'd2;

  typedef struct packed {
    logic           v;
    logic [IDW-1:0] id;
    logic [TW-1:0]  rel;
    logic [TW-1:0]  dl;
    logic [TW-1:0]  per;
  } ent_t;

  function automatic logic beats(ent_t a, ent_t b, logic [1:0] sel);
    logic [TW-1:0] ka, kb;
    ka = (sel == K_DL) ? a.dl : (sel == K_PER) ? a.per : a.rel;
    kb = (sel == K_DL) ? b.dl : (sel == K_PER) ? b.per : b.rel;
    if (!a.v) return 1'b0;
    if (!b.v) return 1'b1;
    return (ka < kb) || (ka == kb && a.id < b.id);
  endfunction

  ent_t sq [NTASK];
  ent_t rq [NTASK];
  ent_t sq_n [NTASK];
  ent_t rq_n [NTASK];
  logic [TW-1:0] tper [NTASK];
  logic [TW-1:0] trdl [NTASK];
  logic ph;

  wire rel_ok = sq[0].v && (sq[0].rel <= now);
  wire r_pop  = done && !cfg_we && rq[0].v;
  wire r_ins  = !done && !cfg_we && rel_ok;
  wire s_ins  = cfg_we || r_pop;
  wire [1:0] rkey = mode_rm ? K_PER : K_DL;

  ent_t s_new, r_new;
  assign s_new = cfg_we ? '{1'b1, cfg_id, cfg_rel, {TW{1'b0}}, {TW{1'b0}}}
                        : '{1'b1, rq[0].id, rq[0].rel + rq[0].per, {TW{1'b0}}, {TW{1'b0}}};
  assign r_new = '{1'b1, sq[0].id, sq[0].rel, sq[0].rel + trdl[sq[0].id], tper[sq[0].id]};

  always_comb begin
    logic seen;
    seen = 1'b0;
    sq_n = sq;
    if (s_ins) begin
      for (int i = 0; i < NTASK; i++) begin
        if (seen) sq_n[i] = sq[(i == 0) ? 0 : i - 1];
        else if (beats(s_new, sq[i], K_REL)) begin
          sq_n[i] = s_new;
          seen = 1'b1;
        end
      end
    end else if (r_ins) begin
      for (int i = 0; i < NTASK - 1; i++) sq_n[i] = sq[i + 1];
      sq_n[NTASK-1] = '0;
    end
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    rq_n = rq;
    if (r_ins) begin
      for (int i = 0; i < NTASK; i++) begin
        if (seen) rq_n[i] = rq[(i == 0) ? 0 : i - 1];
        else if (beats(r_new, rq[i], rkey)) begin
          rq_n[i] = r_new;
          seen = 1'b1;
        end
      end
    end else if (r_pop) begin
      for (int i = 0; i < NTASK - 1; i++) rq_n[i] = rq[i + 1];
      rq_n[NTASK-1] = '0;
    end else begin
      for (int i = 0; i < NTASK - 1; i++) begin
        if ((i & 1) == int'(ph) && beats(rq[i+1], rq[i], rkey)) begin
          rq_n[i]   = rq[i+1];
          rq_n[i+1] = rq[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      tper[cfg_id] <= cfg_period;
      trdl[cfg_id] <= cfg_rdl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTASK; i++) begin
        sq[i] <= '0;
        rq[i] <= '0;
      end
      ph        <= 1'b0;
      now       <= '0;
      irq       <= 1'b0;
      cur_valid <= 1'b0;
      cur_id    <= '0;
    end else begin
      sq  <= sq_n;
      rq  <= rq_n;
      ph  <= ~ph;
      if (tick) now <= now + 1'b1;
      if (rq[0].v && (!cur_valid || cur_id != rq[0].id)) begin
        cur_id    <= rq[0].id;
        cur_valid <= 1'b1;
        irq       <= 1'b1;
      end else begin
        if (!rq[0].v) cur_valid <= 1'b0;
        if (ack) irq <= 1'b0;
      end
    end
  end

  a_r9_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> now == $past(now) + 1'b1);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!irq || $rose(cur_valid) || !$stable(cur_id)));

  a_r11_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    r_ins |-> !rq[NTASK-1].v);

  a_r11_sleep_room: assert property (@(posedge clk) disable iff (!rst_n)
    s_ins |-> !sq[NTASK-1].v);

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NTASK - 1; i++) begin
        a_r5_sleep_sorted: assert (!sq[i+1].v || (sq[i].v && sq[i].rel <= sq[i+1].rel));
        a_r6_ready_packed: assert (!rq[i+1].v || rq[i].v);
      end
    end
  end
endmodule

// File: tb/rt_task_sched_tb.sv
`timescale 1ns/1ps
module rt_task_sched_tb_top;
  localparam int N = 4, TW = 16, IDW = 2;

  logic clk = 0, rst_n = 0, mode_rm = 0, tick = 0, cfg_we = 0, done = 0, ack = 0;
  logic [IDW-1:0] cfg_id = '0;
  logic [TW-1:0] cfg_period = '0, cfg_rdl = '0, cfg_rel = '0;
  logic irq, cur_valid;
  logic [IDW-1:0] cur_id;
  logic [TW-1:0] now;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rt_task_sched #(.NTASK(N), .TW(TW), .IDW(IDW)) dut_i (
    .clk, .rst_n, .mode_rm, .tick, .cfg_we, .cfg_id, .cfg_period, .cfg_rdl,
    .cfg_rel, .done, .ack, .irq, .cur_valid, .cur_id, .now);

  int P [N] = '{10, 6, 8, 6};
  int D [N] = '{9, 6, 3, 9};

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic wr(int id, int per, int rdl, int rel);
    @(negedge clk);
    cfg_we = 1; cfg_id = IDW'(id); cfg_period = TW'(per); cfg_rdl = TW'(rdl); cfg_rel = TW'(rel);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_ack(); @(negedge clk); ack = 1; @(negedge clk); ack = 0; endtask
  task automatic pulse_done(); @(negedge clk); done = 1; @(negedge clk); done = 0; endtask
  task automatic ticks(int n); @(negedge clk); tick = 1; cyc(n); tick = 0; endtask

  function automatic int best(logic [N-1:0] mask, logic m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (mask[i] && (b < 0 || (m ? P[i] : D[i]) < (m ? P[b] : D[b]))) b = i;
    return b;
  endfunction

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pi = 0;
    for (int a = 0; a < N; a++)
    for (int b = 0; b < N; b++)
    for (int c = 0; c < N; c++)
    for (int d = 0; d < N; d++) begin
      if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
      begin
        int perm [N];
        logic m;
        logic [N-1:0] mask;
        perm = '{a, b, c, d};
        m = pi[0];
        mode_rm = m;
        do_reset();
        chk("R1 irq", int'(irq), 0);
        chk("R1 cur_valid", int'(cur_valid), 0);
        chk("R1 now", int'(now), 0);
        for (int k = 0; k < N; k++) wr(perm[k], P[perm[k]], D[perm[k]], 0);
        mask = '1;
        for (int k = 0; k < N; k++) begin
          int e;
          if (k == 2) begin m = ~m; mode_rm = m; end
          cyc(12);
          e = best(mask, m);
          chk(k >= 2 ? "R4 order after mode change" : (m ? "R3 period order" : "R2 deadline order"),
              int'(cur_id), e);
          chk("R7 irq on switch", int'(irq), 1);
          pulse_ack();
          chk("R8 irq cleared", int'(irq), 0);
          pulse_done();
          mask[e] = 1'b0;
        end
        cyc(12);
        chk("R10 empty ready queue", int'(cur_valid), 0);
        pi++;
      end
    end

    mode_rm = 0;
    do_reset();
    wr(0, 10, 9, 5);
    wr(1, 4, 2, 0);
    cyc(8);
    chk("R5 released at time 0", int'(cur_valid), 1);
    chk("R5 released id", int'(cur_id), 1);
    pulse_ack();
    pulse_done();
    cyc(8);
    chk("R10 nothing ready", int'(cur_valid), 0);
    ticks(3);
    chk("R9 now after 3 ticks", int'(now), 3);
    cyc(8);
    chk("R5 not released early", int'(cur_valid), 0);
    ticks(1);
    cyc(8);
    chk("R6 next release at rel+period", int'(cur_valid), 1);
    chk("R6 rereleased id", int'(cur_id), 1);
    pulse_ack();
    ticks(1);
    cyc(8);
    chk("R9 now", int'(now), 5);
    chk("R2 earlier deadline keeps running", int'(cur_id), 1);
    chk("R7 no spurious irq", int'(irq), 0);
    pulse_done();
    cyc(8);
    chk("R6 switch after done", int'(cur_id), 0);
    chk("R7 irq after done", int'(irq), 1);
    pulse_ack();
    mode_rm = 1;
    cyc(8);
    chk("R4 single task after mode change", int'(cur_id), 0);
    ticks(3);
    cyc(8);
    chk("R9 now", int'(now), 8);
    chk("R3 shorter period preempts", int'(cur_id), 1);
    chk("R7 irq on preempt", int'(irq), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule